// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block connects a simple register-style host port to an 8-bit NAND flash device. It turns each host write to the command or address port into one latch cycle, and each data-port access into one or four byte cycles. Every byte cycle has three phases: setup, strobe low, and hold. The length of each phase comes from a timing configuration register. The block drives the active-low chip-enable line from a configuration bit, and it reports the device ready line as a status bit.

The host decodes a 3-bit offset. Offset 0 is configuration (read/write). Offset 1 is the command port and offset 2 the address port (both write). Offset 3 is the data port: a write sends bytes, a read request fetches bytes, and a plain read returns the captured data. Offset 4 is status. The `hostWord` input picks a 32-bit data access (four byte cycles) over a single byte. A host that polls `hostBusy` low can start the next access. The basic variant has a 2-bit setup field. Setting the parameter `EXT_SETUP` gives a 3-bit setup field.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset, nandCeN is 1, nandWeN and nandReN are 1, nandCle, nandAle, nandDqOe and hostBusy are 0, and the configuration register (offset 0) reads 0x0000_2000.
- R2: A write to offset 1 while enabled produces one byte cycle. nandCle is high for the whole cycle and nandAle stays low. nandDqOut carries hostWrData[7:0].
- R3: A write to offset 2 while enabled produces one byte cycle. nandAle is high for the whole cycle and nandCle stays low. nandDqOut carries hostWrData[7:0].
- R4: The configuration fields are hold in bits [2:0], strobe in [6:4] and setup in [10:8], each stored as ticks minus one. For field values s, a and h, the write strobe is low for exactly a+1 cycles. It falls s+1 cycles after the first cycle of the latch window. The latch line is high for s+a+h+3 cycles.
- R5: In the basic variant (EXT_SETUP=0), only bits [9:8] of the setup field are stored. Bit 10 reads back 0, and a written value of 7 acts as 3.
- R6: nandDqOe is high for every cycle of a write-type byte cycle (setup through hold), and the bus holds the byte throughout. The strobes are high during the setup and hold phases.
- R7: A word write (offset 3, hostWord=1) produces four byte cycles with nandCle and nandAle low, sending the least significant byte first. hostBusy stays high from the first setup until the last hold ends: 4*(s+a+h+3) cycles.
- R8: A read request (hostRdEn at offset 3) pulses nandReN low for a+1 cycles per byte and captures nandDqIn as nandReN rises. A byte read returns the byte in bits [7:0] with zeros above it. A word read puts byte i in bits [8i+7:8i]. Offset 3 returns the captured value.
- R9: Configuration bit 13 drives nandCeN: 1 deselects (line high) and 0 selects (line low).
- R10: Bit 0 at offset 4 equals nandRdy (1 means ready) through a two-flop synchronizer, and is visible within three cycles.
- R11: While configuration bit 12 (enable) is 0, accesses to offsets 1, 2 and 3 cause no strobe, no latch, no bus drive and no busy.
- R12: Command, address and data accesses made while hostBusy is high are ignored: they add no cycle and change no latch line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read request (starts byte reads at offset 3) |
| hostAddr | input | 3 | Register offset |
| hostWord | input | 1 | Data port access is 32-bit (1) or a single byte (0) |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Register read data for hostAddr |
| hostBusy | output | 1 | A bus access is in progress |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandDqOut | output | 8 | Data bus out |
| nandDqOe | output | 1 | Data bus output enable |
| nandDqIn | input | 8 | Data bus in |
| nandRdy | input | 1 | Device ready (1) / busy (0) |

## Verification
A wrong phase counter, or a wrong reload of the counter, changes the strobe width or the latch window length within the first byte cycle. That is a few tens of clocks at most. It shows directly in the count of strobe-low cycles, and in the offset of the strobe edge from the latch edge. A byte index that is off, or a shift register that is wrong, shows up as a misordered or repeated byte on the bus, or in the captured read word, within one word access. A busy flag or enable gate that leaks shows up as an extra strobe edge or a stray latch pulse in the cycles after the access that should have been dropped.

// File: rtl/nand_seq_pkg.sv
`timescale 1ns/1ps
package nand_seq_pkg;
  localparam logic [2:0] ADR_CFG  = 3'd0;
  localparam logic [2:0] ADR_CMD  = 3'd1;
  localparam logic [2:0] ADR_ADDR = 3'd2;
  localparam logic [2:0] ADR_DATA = 3'd3;
  localparam logic [2:0] ADR_STAT = 3'd4;

  localparam int CFG_EN_BIT = 12;
  localparam int CFG_CE_BIT = 13;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACTIVE, PH_HOLD} phase_e;
  typedef enum logic [1:0] {K_CMD, K_ADDR, K_WRITE, K_READ} kind_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic       txLoad;
    logic       txShift;
    logic       rxClear;
    logic       rxCapture;
    logic [1:0] byteSel;
  } dpStrobe_t;
endpackage

// File: rtl/nand_seq_ctrl.sv
`timescale 1ns/1ps
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int SETUP_W = 2,
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic               hostRdEn,
  input  logic [2:0]         hostAddr,
  input  logic               hostWord,
  input  logic               enable,
  input  logic [SETUP_W-1:0] setupTicks,
  input  logic [PHASE_W-1:0] activeTicks,
  input  logic [PHASE_W-1:0] holdTicks,
  output logic               busy,
  output logic               cle,
  output logic               ale,
  output logic               weN,
  output logic               reN,
  output logic               dqDrive,
  output dpStrobe_t          strobe
);
  localparam int CNT_W = (SETUP_W > PHASE_W) ? SETUP_W : PHASE_W;

  phase_e           phase;
  kind_e            kind;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       byteIdx;
  logic [1:0]       lastIdx;

  logic isCmd, isAddr, isData, startWr, startRd, phaseDone, lastByte;

  assign isCmd     = (hostAddr == ADR_CMD);
  assign isAddr    = (hostAddr == ADR_ADDR);
  assign isData    = (hostAddr == ADR_DATA);
  assign busy      = (phase != PH_IDLE);
  assign startWr   = !busy && enable && hostWrEn && (isCmd || isAddr || isData);
  assign startRd   = !busy && enable && !hostWrEn && hostRdEn && isData;
  assign phaseDone = (cnt == '0);
  assign lastByte  = (byteIdx == lastIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      kind    <= K_CMD;
      cnt     <= '0;
      byteIdx <= '0;
      lastIdx <= '0;
    end else if (startWr || startRd) begin
      phase   <= PH_SETUP;
      cnt     <= CNT_W'(setupTicks);
      byteIdx <= '0;
      lastIdx <= (isData && hostWord) ? 2'd3 : 2'd0;
      if (startRd)     kind <= K_READ;
      else if (isCmd)  kind <= K_CMD;
      else if (isAddr) kind <= K_ADDR;
      else             kind <= K_WRITE;
    end else begin
      unique case (phase)
        PH_SETUP: begin
          if (phaseDone) begin
            phase <= PH_ACTIVE;
            cnt   <= CNT_W'(activeTicks);
          end else cnt <= cnt - 1'b1;
        end
        PH_ACTIVE: begin
          if (phaseDone) begin
            phase <= PH_HOLD;
            cnt   <= CNT_W'(holdTicks);
          end else cnt <= cnt - 1'b1;
        end
        PH_HOLD: begin
          if (phaseDone) begin
            if (lastByte) phase <= PH_IDLE;
            else begin
              phase   <= PH_SETUP;
              cnt     <= CNT_W'(setupTicks);
              byteIdx <= byteIdx + 1'b1;
            end
          end else cnt <= cnt - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.txLoad    = startWr;
    strobe.txShift   = (phase == PH_HOLD) && phaseDone && !lastByte;
    strobe.rxClear   = startRd;
    strobe.rxCapture = (phase == PH_ACTIVE) && phaseDone && (kind == K_READ);
    strobe.byteSel   = byteIdx;
  end

  assign cle     = busy && (kind == K_CMD);
  assign ale     = busy && (kind == K_ADDR);
  assign weN     = !((phase == PH_ACTIVE) && (kind != K_READ));
  assign reN     = !((phase == PH_ACTIVE) && (kind == K_READ));
  assign dqDrive = busy && (kind != K_READ);

  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!weN && !reN));
  a_r2_latches_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(cle && ale));
  a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !enable) |=> !busy);
  a_r12_kind_held: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(kind));
  a_r7_busy_ends_last_hold: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(phase == PH_HOLD && lastByte));
  a_r4_starts_in_setup: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (phase == PH_SETUP && weN && reN));
endmodule

// File: rtl/nand_seq_dp.sv
`timescale 1ns/1ps
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int SETUP_W = 2,
  parameter int PHASE_W = 3,
  parameter int WORD_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic [2:0]         hostAddr,
  input  logic [WORD_W-1:0]  hostWrData,
  input  dpStrobe_t          strobe,
  input  logic [7:0]         dqIn,
  input  logic               rdyIn,
  output logic [WORD_W-1:0]  hostRdData,
  output logic               ceN,
  output logic               enable,
  output logic [SETUP_W-1:0] setupTicks,
  output logic [PHASE_W-1:0] activeTicks,
  output logic [PHASE_W-1:0] holdTicks,
  output logic [7:0]         dqOut
);
  localparam int ACT_LSB   = 4;
  localparam int SETUP_LSB = 8;

  logic              cfgWr;
  logic [WORD_W-1:0] cfgWord;
  logic [WORD_W-1:0] txR;
  logic [WORD_W-1:0] rxR;
  logic [1:0]        rdySync;

  assign cfgWr = hostWrEn && (hostAddr == ADR_CFG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setupTicks  <= '0;
      activeTicks <= '0;
      holdTicks   <= '0;
      enable      <= 1'b0;
      ceN         <= 1'b1;
    end else if (cfgWr) begin
      holdTicks   <= hostWrData[PHASE_W-1:0];
      activeTicks <= hostWrData[ACT_LSB +: PHASE_W];
      setupTicks  <= hostWrData[SETUP_LSB +: SETUP_W];
      enable      <= hostWrData[CFG_EN_BIT];
      ceN         <= hostWrData[CFG_CE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txR     <= '0;
      rxR     <= '0;
      rdySync <= '0;
    end else begin
      rdySync <= {rdySync[0], rdyIn};
      if (strobe.txLoad)       txR <= hostWrData;
      else if (strobe.txShift) txR <= txR >> 8;
      if (strobe.rxClear)        rxR <= '0;
      else if (strobe.rxCapture) rxR[{strobe.byteSel, 3'b000} +: 8] <= dqIn;
    end
  end

  assign dqOut = txR[7:0];

  always_comb begin
    cfgWord = '0;
    cfgWord[PHASE_W-1:0]           = holdTicks;
    cfgWord[ACT_LSB +: PHASE_W]    = activeTicks;
    cfgWord[SETUP_LSB +: SETUP_W]  = setupTicks;
    cfgWord[CFG_EN_BIT]            = enable;
    cfgWord[CFG_CE_BIT]            = ceN;
    unique case (hostAddr)
      ADR_CFG:  hostRdData = cfgWord;
      ADR_DATA: hostRdData = rxR;
      ADR_STAT: hostRdData = {{(WORD_W-1){1'b0}}, rdySync[1]};
      default:  hostRdData = '0;
    endcase
  end

  a_r9_ce_only_by_cfg: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfgWr) |-> $stable(ceN));
  a_r8_read_starts_clear: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.rxClear) |-> (rxR == '0));
  a_r7_no_load_and_shift: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.txLoad && strobe.txShift));
endmodule

// File: rtl/nand_cycle_seq.sv
`timescale 1ns/1ps
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int EXT_SETUP = 0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic        hostRdEn,
  input  logic [2:0]  hostAddr,
  input  logic        hostWord,
  input  logic [31:0] hostWrData,
  output logic [31:0] hostRdData,
  output logic        hostBusy,
  output logic        nandCeN,
  output logic        nandCle,
  output logic        nandAle,
  output logic        nandWeN,
  output logic        nandReN,
  output logic [7:0]  nandDqOut,
  output logic        nandDqOe,
  input  logic [7:0]  nandDqIn,
  input  logic        nandRdy
);
  localparam int SETUP_W = (EXT_SETUP != 0) ? 3 : 2;
  localparam int PHASE_W = 3;

  dpStrobe_t          strobe;
  logic               enable;
  logic [SETUP_W-1:0] setupTicks;
  logic [PHASE_W-1:0] activeTicks;
  logic [PHASE_W-1:0] holdTicks;

  nand_seq_ctrl #(.SETUP_W(SETUP_W), .PHASE_W(PHASE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWord(hostWord), .enable(enable),
    .setupTicks(setupTicks), .activeTicks(activeTicks), .holdTicks(holdTicks),
    .busy(hostBusy), .cle(nandCle), .ale(nandAle), .weN(nandWeN),
    .reN(nandReN), .dqDrive(nandDqOe), .strobe(strobe)
  );

  nand_seq_dp #(.SETUP_W(SETUP_W), .PHASE_W(PHASE_W), .WORD_W(32)) dp_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .strobe(strobe), .dqIn(nandDqIn), .rdyIn(nandRdy),
    .hostRdData(hostRdData), .ceN(nandCeN), .enable(enable),
    .setupTicks(setupTicks), .activeTicks(activeTicks), .holdTicks(holdTicks),
    .dqOut(nandDqOut)
  );
endmodule

// File: tb/nand_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module nand_cycle_seq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic        hostRdEn = 1'b0;
  logic [2:0]  hostAddr = 3'd0;
  logic        hostWord = 1'b0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        hostBusy, nandCeN, nandCle, nandAle, nandWeN, nandReN, nandDqOe;
  logic [7:0]  nandDqOut;
  logic [7:0]  nandDqIn = 8'h00;
  logic        nandRdy = 1'b1;

  always #2 clk = ~clk;  // 250 MHz

  nand_cycle_seq dut_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWord(hostWord), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .hostBusy(hostBusy), .nandCeN(nandCeN),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
    .nandDqOut(nandDqOut), .nandDqOe(nandDqOe), .nandDqIn(nandDqIn), .nandRdy(nandRdy)
  );

  // device model: next read byte appears when the read strobe falls
  int rdIdx = 0;
  function automatic logic [7:0] rdPat(input int i);
    return 8'(8'h5A + i * 37);
  endfunction
  always @(negedge nandReN) begin
    nandDqIn = rdPat(rdIdx);
    rdIdx = rdIdx + 1;
  end

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // cycle monitor results
  int cleCnt, aleCnt, weLow, reLow, firstWe, weFalls, oeCnt, dqBad, busyCnt, strobeBad;
  logic [7:0] wrBytes [4];

  function automatic logic [31:0] cfgVal(input int s, input int a, input int h, input bit en, input bit ce);
    return 32'(h) | (32'(a) << 4) | (32'(s) << 8) | (32'(en) << 12) | (32'(ce) << 13);
  endfunction

  task automatic hostWrite(input logic [2:0] adr, input logic [31:0] d, input bit word);
    @(negedge clk);
    hostAddr = adr; hostWrData = d; hostWord = word; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0; hostWord = 1'b0;
  endtask

  task automatic hostReadReq(input bit word);
    @(negedge clk);
    hostAddr = 3'd3; hostWord = word; hostRdEn = 1'b1;
    @(negedge clk);
    hostRdEn = 1'b0; hostWord = 1'b0;
  endtask

  // called at the negedge just after acceptance
  task automatic runCycle(input logic [7:0] expByte);
    bit prevWe = 1'b1;
    cleCnt = 0; aleCnt = 0; weLow = 0; reLow = 0; firstWe = -1; weFalls = 0;
    oeCnt = 0; dqBad = 0; busyCnt = 0; strobeBad = 0;
    for (int i = 0; i < 400 && hostBusy; i++) begin
      busyCnt++;
      if (nandCle) cleCnt++;
      if (nandAle) aleCnt++;
      if (!nandWeN) begin weLow++; if (firstWe < 0) firstWe = i; end
      if (!nandReN) reLow++;
      if (prevWe && !nandWeN) begin
        if (weFalls < 4) wrBytes[weFalls] = nandDqOut;
        weFalls++;
      end
      prevWe = nandWeN;
      if (nandDqOe) oeCnt++;
      if (nandDqOe && nandDqOut != expByte) dqBad++;
      if (!nandDqOe && !nandReN) ; else if (!nandDqOe) strobeBad++;
      @(negedge clk);
    end
  endtask

  task automatic quietWindow(input string req, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (hostBusy || nandCle || nandAle || !nandWeN || !nandReN || nandDqOe) bad++;
      @(negedge clk);
    end
    check(bad == 0, req, bad, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    hostAddr = 3'd0; #0.1;
    check(nandCeN && nandWeN && nandReN && !nandCle && !nandAle && !nandDqOe && !hostBusy,
          "R1 pins", {nandCeN, nandWeN, nandReN, nandCle, nandAle, nandDqOe, hostBusy}, 7'b1110000);
    check(hostRdData == 32'h2000, "R1 cfg", hostRdData, 32'h2000);

    // R4 / R2 / R6 sweep over all basic timings
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 8; a++)
        for (int h = 0; h < 8; h++) begin
          logic [7:0] b = 8'(s * 64 + a * 8 + h) ^ 8'hA5;
          hostWrite(3'd0, cfgVal(s, a, h, 1, 0), 0);
          hostWrite(3'd1, {24'hFFFFFF, b}, 0);
          runCycle(b);
          check(cleCnt == s + a + h + 3 && aleCnt == 0, "R2 R4 latch window", cleCnt, s + a + h + 3);
          check(weLow == a + 1 && firstWe == s + 1 && weFalls == 1, "R4 strobe width/offset",
                weLow * 256 + firstWe, (a + 1) * 256 + s + 1);
          check(oeCnt == cleCnt && dqBad == 0 && strobeBad == 0 && wrBytes[0] == b, "R6 bus held",
                dqBad, 0);
        end

    // R3 address port
    for (int k = 0; k < 4; k++) begin
      logic [7:0] b = 8'(8'h30 + k * 17);
      hostWrite(3'd0, cfgVal(k, 3 - k, k, 1, 0), 0);
      hostWrite(3'd2, {24'h0, b}, 0);
      runCycle(b);
      check(aleCnt == 3 + 3 + k && cleCnt == 0 && dqBad == 0 && weFalls == 1 && wrBytes[0] == b,
            "R3 address cycle", aleCnt, 6 + k);
    end

    // R5 basic setup width
    hostWrite(3'd0, cfgVal(7, 0, 0, 1, 0), 0);
    hostAddr = 3'd0; #0.1;
    check(hostRdData[10:8] == 3'd3, "R5 setup readback", hostRdData[10:8], 3);
    hostWrite(3'd1, 32'h77, 0);
    runCycle(8'h77);
    check(cleCnt == 6 && firstWe == 4, "R5 setup acts as 3", cleCnt, 6);

    // R7 word write LSB first
    hostWrite(3'd0, cfgVal(1, 2, 1, 1, 0), 0);
    hostWrite(3'd3, 32'h11223344, 1);
    runCycle(8'h00);
    check(weFalls == 4 && cleCnt == 0 && aleCnt == 0 && weLow == 12, "R7 four strobes", weFalls, 4);
    check({wrBytes[3], wrBytes[2], wrBytes[1], wrBytes[0]} == 32'h11223344, "R7 byte order",
          {wrBytes[3], wrBytes[2], wrBytes[1], wrBytes[0]}, 32'h11223344);
    check(busyCnt == 4 * 7 && oeCnt == busyCnt, "R7 busy span", busyCnt, 28);

    // R8 word read then byte read
    begin
      int base = rdIdx;
      logic [31:0] expW = {rdPat(base + 3), rdPat(base + 2), rdPat(base + 1), rdPat(base)};
      hostReadReq(1);
      runCycle(8'h00);
      check(reLow == 12 && weLow == 0 && oeCnt == 0, "R8 read strobes", reLow, 12);
      hostAddr = 3'd3; #0.1;
      check(hostRdData == expW, "R8 word capture", hostRdData, expW);
      hostReadReq(0);
      runCycle(8'h00);
      hostAddr = 3'd3; #0.1;
      check(hostRdData == {24'h0, rdPat(base + 4)}, "R8 byte capture", hostRdData, {24'h0, rdPat(base + 4)});
    end

    // R9 chip enable
    hostWrite(3'd0, cfgVal(0, 0, 0, 1, 1), 0);
    check(nandCeN == 1'b1, "R9 deselect", nandCeN, 1);
    hostWrite(3'd0, cfgVal(0, 0, 0, 1, 0), 0);
    check(nandCeN == 1'b0, "R9 select", nandCeN, 0);

    // R10 ready status
    nandRdy = 1'b0; repeat (3) @(negedge clk);
    hostAddr = 3'd4; #0.1;
    check(hostRdData == 32'h0, "R10 busy seen", hostRdData, 0);
    nandRdy = 1'b1; repeat (3) @(negedge clk);
    hostAddr = 3'd4; #0.1;
    check(hostRdData == 32'h1, "R10 ready seen", hostRdData, 1);

    // R11 disabled
    hostWrite(3'd0, cfgVal(2, 2, 2, 0, 0), 0);
    hostWrite(3'd1, 32'h12, 0);
    quietWindow("R11 cmd while off", 10);
    hostWrite(3'd3, 32'hCAFEF00D, 1);
    quietWindow("R11 data while off", 10);
    hostReadReq(1);
    quietWindow("R11 read while off", 10);

    // R12 accesses while busy are dropped
    hostWrite(3'd0, cfgVal(3, 1, 1, 1, 0), 0);
    hostWrite(3'd1, 32'h3C, 0);
    hostWrite(3'd2, 32'hC3, 0);
    runCycle(8'h3C);
    check(aleCnt == 0 && weFalls == 1 && dqBad == 0, "R12 addr dropped", aleCnt, 0);
    quietWindow("R12 nothing queued", 8);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule